// File: doc/BRIEF.md
# Raw Uncorrectable Error Recovery Sequencer

This block controls recovery when a load or store finds a raw (not yet marked) uncorrectable error in a first-level data cache doubleword. It takes over the access. The line is written back to the second-level cache no matter whether it is clean or dirty, and the bad doubleword is tagged with the current error-mark ID during that writeback. The line is then refilled and the doubleword is checked again. While the raw error keeps coming back, the writeback and refill loop repeats until a retry threshold is reached. At that point the sequencer asks for way reduction. Once way reduction is acknowledged, it converts the raw error into a marked error in place and replays the access.

When an access reads a marked error, the sequencer raises a precise data access trap and records the mark ID in a fault status register. This applies both to an access that finds the mark on its first try and to an access replayed after conversion. Doubleword stores are exempt from this trap. The pipeline stays held for the whole sequence, so a trap is charged to the faulting instruction. The cache arrays and the writeback datapath lie outside this block: each memory step is a request held high until a done strobe returns.

Top module: `rue_seq`

## Requirements
- R1: An access that sees a raw error (accValid and chkRaw high) starts a writeback request (wbReq) in the next cycle. The writeback carries the errMarkId value captured at detection (wbMarkId), and that value stays the same even if errMarkId changes later.
- R2: rawErrSet pulses high for exactly one cycle, in the cycle after the writeback completes (wbReq and wbDone high together).
- R3: A refill request (refillReq) starts in the cycle after the writeback completes. At most one step request (wbReq, refillReq, wayRedReq, convReq) is high in any cycle.
- R4: If chkRaw is low in the cycle after the refill completes, the access replays and accDone pulses for one cycle, with no trap.
- R5: If chkRaw is high again after a refill and fewer than THRESH re-detections have been counted for this access, a new writeback with the same mark ID starts. The count restarts at zero for every new access.
- R6: On the THRESH-th re-detection after a refill (default THRESH=2), wayRedReq goes high and stays high until wayRedAck.
- R7: After wayRedAck, convReq goes high with convMarkId equal to the captured mark ID and stays high until convDone. The access then replays.
- R8: A non-doubleword access that sees chkMarked, either on first detection or on replay, pulses trapValid for one cycle. In that same cycle fsrMarked is 1 and fsrMarkId holds the chkMarkId value seen at the decision. Both fields keep their values until the next trap.
- R9: A doubleword store (accDwStore=1) that sees a marked error never traps and leaves the fault status unchanged. On replay it finishes with accDone.
- R10: hold is high from the cycle after detection through the cycle of accDone or trapValid, and low in the cycle after that. Every step request and trap happens while hold is high.
- R11: After reset, hold, all requests, rawErrSet, accDone, trapValid and fsrMarked are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Load/store access probing the doubleword this cycle |
| accDwStore | input | 1 | The access is a doubleword store |
| chkRaw | input | 1 | Raw uncorrectable error seen on the doubleword |
| chkMarked | input | 1 | Marked uncorrectable error seen on the doubleword |
| chkMarkId | input | ID_W | Mark ID carried by the marked doubleword |
| errMarkId | input | ID_W | Current error-mark ID register value |
| wbReq | output | 1 | Write back the line with marking |
| wbMarkId | output | ID_W | Mark ID to apply during writeback |
| wbDone | input | 1 | Writeback finished |
| refillReq | output | 1 | Refill line from second-level cache |
| refillDone | input | 1 | Refill finished |
| wayRedReq | output | 1 | Way reduction request |
| wayRedAck | input | 1 | Way reduction applied |
| convReq | output | 1 | Convert raw error to marked in place |
| convMarkId | output | ID_W | Mark ID used for the conversion |
| convDone | input | 1 | Conversion finished |
| rawErrSet | output | 1 | One-cycle pulse setting the restrainable raw-error status |
| accDone | output | 1 | Replayed access finished without a trap |
| trapValid | output | 1 | Precise data access trap |
| fsrMarked | output | 1 | Fault status: marked error detected |
| fsrMarkId | output | ID_W | Fault status: recorded mark ID |
| hold | output | 1 | Pipeline hold |

## Verification
A wrong FSM state or a wrong retry count shows up at the ports as a missing, extra or reordered step request. For example, a writeback appears where a way-reduction request should be, or a replay happens too early. This becomes visible within a few cycles of the handshake that ends the step. A wrong captured mark ID or doubleword-store flag only shows up later, as a wrong wbMarkId on a repeated writeback or as a trap that should not happen, possibly several steps after detection. So the bench checks every step against an expected ordered list and also checks the fault status after each access.

// File: rtl/rue_pkg.sv
package rue_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WB, ST_REFILL, ST_RECHECK, ST_WAYRED, ST_CONVERT, ST_REPLAY, ST_TRAP
  } rue_state_e;

  typedef struct packed {
    logic capture;   // latch access info and mark ID
    logic cntInc;    // count a raw re-detection
    logic setStatus; // restrainable raw-error status pulse
    logic fsrLoad;   // record marked error in fault status
  } rue_strobe_t;
endpackage

// File: rtl/rue_dpath.sv
module rue_dpath
  import rue_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int THRESH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  rue_strobe_t     stb,
  input  logic            accDwStore,
  input  logic [ID_W-1:0] errMarkId,
  input  logic [ID_W-1:0] chkMarkId,
  output logic            dwQ,
  output logic            cntHit,
  output logic [ID_W-1:0] markIdQ,
  output logic            statusQ,
  output logic            fsrMarked,
  output logic [ID_W-1:0] fsrMarkId
);
  localparam int CNT_W = $clog2(THRESH + 1);

  logic [CNT_W-1:0] retryCnt;

  assign cntHit = ({1'b0, retryCnt} + (CNT_W+1)'(1)) >= (CNT_W+1)'(THRESH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwQ       <= 1'b0;
      retryCnt  <= '0;
      markIdQ   <= '0;
      statusQ   <= 1'b0;
      fsrMarked <= 1'b0;
      fsrMarkId <= '0;
    end else begin
      statusQ <= stb.setStatus;
      if (stb.capture) begin
        dwQ      <= accDwStore;
        markIdQ  <= errMarkId;
        retryCnt <= '0;
      end else if (stb.cntInc) begin
        retryCnt <= retryCnt + CNT_W'(1);
      end
      if (stb.fsrLoad) begin
        fsrMarked <= 1'b1;
        fsrMarkId <= chkMarkId;
      end
    end
  end
endmodule

// File: rtl/rue_ctrl.sv
module rue_ctrl
  import rue_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        accValid,
  input  logic        accDwStore,
  input  logic        chkRaw,
  input  logic        chkMarked,
  input  logic        wbDone,
  input  logic        refillDone,
  input  logic        wayRedAck,
  input  logic        convDone,
  input  logic        dwQ,
  input  logic        cntHit,
  output rue_strobe_t stb,
  output logic        wbReq,
  output logic        refillReq,
  output logic        wayRedReq,
  output logic        convReq,
  output logic        accDone,
  output logic        trapValid,
  output logic        hold
);
  rue_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    accDone   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (accValid && chkRaw) begin
          stb.capture = 1'b1;
          nextState   = ST_WB;
        end else if (accValid && chkMarked && !accDwStore) begin
          stb.fsrLoad = 1'b1;
          nextState   = ST_TRAP;
        end
      end
      ST_WB: if (wbDone) begin
        stb.setStatus = 1'b1;
        nextState     = ST_REFILL;
      end
      ST_REFILL: if (refillDone) nextState = ST_RECHECK;
      ST_RECHECK: begin
        if (chkRaw) begin
          stb.cntInc = 1'b1;
          nextState  = cntHit ? ST_WAYRED : ST_WB;
        end else begin
          nextState = ST_REPLAY;
        end
      end
      ST_WAYRED:  if (wayRedAck) nextState = ST_CONVERT;
      ST_CONVERT: if (convDone)  nextState = ST_REPLAY;
      ST_REPLAY: begin
        if (chkMarked && !dwQ) begin
          stb.fsrLoad = 1'b1;
          nextState   = ST_TRAP;
        end else begin
          accDone   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      ST_TRAP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign wbReq     = (state == ST_WB);
  assign refillReq = (state == ST_REFILL);
  assign wayRedReq = (state == ST_WAYRED);
  assign convReq   = (state == ST_CONVERT);
  assign trapValid = (state == ST_TRAP);
  assign hold      = (state != ST_IDLE);
endmodule

// File: rtl/rue_seq.sv
module rue_seq
  import rue_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int THRESH = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            accValid,
  input  logic            accDwStore,
  input  logic            chkRaw,
  input  logic            chkMarked,
  input  logic [ID_W-1:0] chkMarkId,
  input  logic [ID_W-1:0] errMarkId,
  output logic            wbReq,
  output logic [ID_W-1:0] wbMarkId,
  input  logic            wbDone,
  output logic            refillReq,
  input  logic            refillDone,
  output logic            wayRedReq,
  input  logic            wayRedAck,
  output logic            convReq,
  output logic [ID_W-1:0] convMarkId,
  input  logic            convDone,
  output logic            rawErrSet,
  output logic            accDone,
  output logic            trapValid,
  output logic            fsrMarked,
  output logic [ID_W-1:0] fsrMarkId,
  output logic            hold
);
  rue_strobe_t     stb;
  logic            dwQ, cntHit;
  logic [ID_W-1:0] markIdQ;

  rue_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accDwStore(accDwStore),
    .chkRaw(chkRaw), .chkMarked(chkMarked), .wbDone(wbDone),
    .refillDone(refillDone), .wayRedAck(wayRedAck), .convDone(convDone),
    .dwQ(dwQ), .cntHit(cntHit), .stb(stb), .wbReq(wbReq),
    .refillReq(refillReq), .wayRedReq(wayRedReq), .convReq(convReq),
    .accDone(accDone), .trapValid(trapValid), .hold(hold)
  );

  rue_dpath #(.ID_W(ID_W), .THRESH(THRESH)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .accDwStore(accDwStore),
    .errMarkId(errMarkId), .chkMarkId(chkMarkId), .dwQ(dwQ),
    .cntHit(cntHit), .markIdQ(markIdQ), .statusQ(rawErrSet),
    .fsrMarked(fsrMarked), .fsrMarkId(fsrMarkId)
  );

  assign wbMarkId   = markIdQ;
  assign convMarkId = markIdQ;
endmodule

// File: rtl/rue_chk.sv
module rue_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            wbReq,
  input logic            wbDone,
  input logic [ID_W-1:0] wbMarkId,
  input logic            refillReq,
  input logic            wayRedReq,
  input logic            wayRedAck,
  input logic            convReq,
  input logic            convDone,
  input logic            rawErrSet,
  input logic            accDone,
  input logic            trapValid,
  input logic            fsrMarked,
  input logic            hold
);
  assert_wb_id_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    wbReq && $past(wbReq) |-> $stable(wbMarkId));

  assert_status_after_wb_R2: assert property (@(posedge clk) disable iff (!rstN)
    rawErrSet |-> $past(wbReq && wbDone));

  assert_one_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wbReq, refillReq, wayRedReq, convReq}));

  assert_wayred_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    wayRedReq && !wayRedAck |=> wayRedReq);

  assert_conv_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone |=> convReq);

  assert_trap_records_R8: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> fsrMarked);

  assert_steps_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wbReq || refillReq || wayRedReq || convReq || trapValid || accDone) |-> hold);

  assert_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid || accDone) |=> !hold);
endmodule

bind rue_seq rue_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rstN(rstN), .wbReq(wbReq), .wbDone(wbDone), .wbMarkId(wbMarkId),
  .refillReq(refillReq), .wayRedReq(wayRedReq), .wayRedAck(wayRedAck),
  .convReq(convReq), .convDone(convDone), .rawErrSet(rawErrSet),
  .accDone(accDone), .trapValid(trapValid), .fsrMarked(fsrMarked), .hold(hold)
);

// File: tb/sim_rue_seq.sv
module sim_rue_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 8;

  localparam int K_WB = 1, K_STAT = 2, K_REFILL = 3, K_WAYRED = 4,
                 K_CONV = 5, K_DONE = 6, K_TRAP = 7;

  typedef struct {
    int              kind;
    logic [ID_W-1:0] id;
  } ev_t;

  logic clk = 0, rstN = 0;
  logic accValid = 0, accDwStore = 0, chkRaw = 0, chkMarked = 0;
  logic [ID_W-1:0] chkMarkId = '0, errMarkId = '0;
  logic wbDone = 0, refillDone = 0, wayRedAck = 0, convDone = 0;
  logic wbReq, refillReq, wayRedReq, convReq, rawErrSet, accDone, trapValid;
  logic fsrMarked, hold;
  logic [ID_W-1:0] wbMarkId, convMarkId, fsrMarkId;

  ev_t expQ[$];
  int  tests = 0, fails = 0;
  int  rawLeft = 0;
  logic [ID_W-1:0] convId = '0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rue_seq #(.ID_W(ID_W), .THRESH(2)) u0 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accDwStore(accDwStore),
    .chkRaw(chkRaw), .chkMarked(chkMarked), .chkMarkId(chkMarkId),
    .errMarkId(errMarkId), .wbReq(wbReq), .wbMarkId(wbMarkId), .wbDone(wbDone),
    .refillReq(refillReq), .refillDone(refillDone), .wayRedReq(wayRedReq),
    .wayRedAck(wayRedAck), .convReq(convReq), .convMarkId(convMarkId),
    .convDone(convDone), .rawErrSet(rawErrSet), .accDone(accDone),
    .trapValid(trapValid), .fsrMarked(fsrMarked), .fsrMarkId(fsrMarkId),
    .hold(hold)
  );

  function automatic string reqTag(int k);
    case (k)
      K_WB:     return "R1/R5 writeback";
      K_STAT:   return "R2 raw status";
      K_REFILL: return "R3 refill";
      K_WAYRED: return "R6 way reduction";
      K_CONV:   return "R7 convert";
      K_DONE:   return "R4 replay done";
      K_TRAP:   return "R8 trap";
      default:  return "R3 sequence";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(int k, logic [ID_W-1:0] id);
    ev_t e;
    e.kind = k; e.id = id;
    expQ.push_back(e);
  endtask

  task automatic observe(int k, logic [ID_W-1:0] id);
    ev_t e;
    check(hold, "R10 step under hold", hold, 1);
    if (expQ.size() == 0) begin
      check(0, reqTag(k), k, 0);
    end else begin
      e = expQ.pop_front();
      check(e.kind == k, reqTag(e.kind), k, e.kind);
      if (e.kind == k && (k == K_WB || k == K_CONV || k == K_TRAP))
        check(id == e.id, {reqTag(k), " id"}, id, e.id);
    end
  endtask

  // Monitor: compares step events against the expected queue.
  initial begin
    logic pWb = 0, pRf = 0, pWr = 0, pCv = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (wbReq && !pWb)     observe(K_WB, wbMarkId);
        if (rawErrSet)         observe(K_STAT, '0);
        if (refillReq && !pRf) observe(K_REFILL, '0);
        if (wayRedReq && !pWr) observe(K_WAYRED, '0);
        if (convReq && !pCv)   observe(K_CONV, convMarkId);
        if (accDone)           observe(K_DONE, '0);
        if (trapValid) begin
          observe(K_TRAP, fsrMarkId);
          check(fsrMarked, "R8 fsr marked at trap", fsrMarked, 1);
        end
      end
      pWb = wbReq; pRf = refillReq; pWr = wayRedReq; pCv = convReq;
    end
  end

  // Responder: memory steps finish after fixed latencies.
  initial begin
    int cWb = 0, cRf = 0, cWr = 0, cCv = 0;
    forever begin
      @(negedge clk);
      if (wbDone) wbDone = 0;
      else if (wbReq) begin cWb++; if (cWb == 2) begin wbDone = 1; cWb = 0; end end
      if (refillDone) refillDone = 0;
      else if (refillReq) begin
        cRf++;
        if (cRf == 3) begin
          refillDone = 1; cRf = 0;
          rawLeft--;
          chkRaw = (rawLeft > 0);
        end
      end
      if (wayRedAck) wayRedAck = 0;
      else if (wayRedReq) begin cWr++; if (cWr == 4) begin wayRedAck = 1; cWr = 0; end end
      if (convDone) convDone = 0;
      else if (convReq) begin
        cCv++;
        if (cCv == 2) begin
          convDone = 1; cCv = 0;
          chkMarked = 1; chkRaw = 0; chkMarkId = convId;
        end
      end
    end
  end

  task automatic access(bit dw, bit raw, bit marked, int nRaw,
                        logic [ID_W-1:0] id, logic [ID_W-1:0] mid);
    @(negedge clk);
    errMarkId = id; convId = id; rawLeft = nRaw;
    accValid = 1; accDwStore = dw; chkRaw = raw; chkMarked = marked; chkMarkId = mid;
    @(negedge clk);
    accValid = 0;
    errMarkId = ~id;  // later changes must not affect the captured ID
    if (!raw) chkMarked = 0;
    repeat (2) @(negedge clk);
    while (hold) @(negedge clk);
    @(negedge clk);
    chkRaw = 0; chkMarked = 0;
    check(!hold, "R10 hold released", hold, 0);
    check(expQ.size() == 0, "R3 all expected steps seen", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!hold && !wbReq && !refillReq && !wayRedReq && !convReq, "R11 idle after reset",
          {hold, wbReq, refillReq, wayRedReq, convReq}, 0);
    check(!fsrMarked && !trapValid && !accDone && !rawErrSet, "R11 status clear after reset",
          {fsrMarked, trapValid, accDone, rawErrSet}, 0);
    rstN = 1;

    // Raw error cleared by one refill
    push(K_WB, 8'h11); push(K_STAT, 0); push(K_REFILL, 0); push(K_DONE, 0);
    access(0, 1, 0, 1, 8'h11, 8'h00);

    // Raw error cleared after one repeat (below threshold)
    push(K_WB, 8'h22); push(K_STAT, 0); push(K_REFILL, 0);
    push(K_WB, 8'h22); push(K_STAT, 0); push(K_REFILL, 0); push(K_DONE, 0);
    access(0, 1, 0, 2, 8'h22, 8'h00);

    // Doubleword store hitting a marked error: ignored
    access(1, 0, 1, 0, 8'h33, 8'h44);
    check(!fsrMarked, "R9 dw store leaves fsr clear", fsrMarked, 0);

    // Persistent raw error: way reduction, convert, trap
    push(K_WB, 8'h5C); push(K_STAT, 0); push(K_REFILL, 0);
    push(K_WB, 8'h5C); push(K_STAT, 0); push(K_REFILL, 0);
    push(K_WAYRED, 0); push(K_CONV, 8'h5C); push(K_TRAP, 8'h5C);
    access(0, 1, 0, 9, 8'h5C, 8'h00);
    check(fsrMarked && fsrMarkId == 8'h5C, "R8 fsr after converted trap", fsrMarkId, 8'h5C);

    // Persistent raw on a doubleword store: counter restarts, no trap (R5, R9)
    push(K_WB, 8'h6D); push(K_STAT, 0); push(K_REFILL, 0);
    push(K_WB, 8'h6D); push(K_STAT, 0); push(K_REFILL, 0);
    push(K_WAYRED, 0); push(K_CONV, 8'h6D); push(K_DONE, 0);
    access(1, 1, 0, 9, 8'h6D, 8'h00);
    check(fsrMarkId == 8'h5C, "R9 fsr unchanged by dw store", fsrMarkId, 8'h5C);

    // Load meeting an existing marked error
    push(K_TRAP, 8'hA7);
    access(0, 0, 1, 0, 8'h01, 8'hA7);
    check(fsrMarked && fsrMarkId == 8'hA7, "R8 fsr after direct trap", fsrMarkId, 8'hA7);

    // Store, raw cleared after refill
    push(K_WB, 8'h7E); push(K_STAT, 0); push(K_REFILL, 0); push(K_DONE, 0);
    access(0, 1, 0, 1, 8'h7E, 8'h00);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule